// File: doc/BRIEF.md
# Approximate Keyword Hit Reporter

This block sits behind an approximate keyword matching array and turns its per-cell state into a list of keyword addresses. The stored text is a row of N character cells in which some cells hold a keyword delimiter; each keyword occupies the cells between one delimiter and the next. When the input word finishes, the caller raises `word_end_i` for one cycle, together with the per-cell compare bits and the error-distance state bits PE(i,j) for j = 0..D. A delimiter cell whose compare bit is set and which holds at least one state bit reports a hit. That hit is translated into the address of the first cell of its keyword.

All hits of one word are captured at once into a pending vector indexed by keyword start address. A binary-tree priority encoder then drains that vector, reporting one address per cycle in ascending order. Each address comes with the smallest error count at which its keyword matched. After the last address, a done pulse closes the run. A run with q hits therefore occupies q+1 cycles after the end-of-word cycle is accepted. Together with the p cycles of streaming and the capture cycle, the full word takes p+q+2 cycles.

Top module: `wmatch_addr_encoder`

## Requirements
- R1: After reset, `busy_o`, `hit_valid_o` and `done_o` are all 0.
- R2: A hit at cell i exists only when `word_end_i` is accepted, `delim_i[i]`=1, `cmp_hit_i[i]`=1 and at least one of `pe_state_i[i*(D+1)+j]`, j=0..D, is 1. Cells without a delimiter never produce a hit, and no run starts while `word_end_i` stays 0.
- R3: The reported address of a hit at delimiter cell i is k+1, where k is the highest delimiter index below i. If no delimiter lies below i, the address is 0.
- R4: Hit addresses appear with `hit_valid_o`=1 on consecutive cycles, in strictly ascending order. The first one appears in the cycle after `word_end_i` is accepted.
- R5: `done_o` is 1 for exactly one cycle, in the cycle after the last valid address. With zero hits it is 1 in the cycle after acceptance. It is therefore high q+1 cycles after acceptance.
- R6: A `word_end_i` pulse while `busy_o`=1 (including the done cycle) is ignored. It neither alters the reported list nor starts a new run.
- R7: `hit_dist_o` equals the lowest j for which PE(i,j) of the hitting delimiter cell is 1.
- R8: `busy_o` is 1 from the cycle after acceptance through the done cycle, and 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_end_i | input | 1 | Input word finished; accepted when not busy |
| delim_i | input | N | Per-cell flag: stored cell is a keyword delimiter |
| cmp_hit_i | input | N | Per-cell character compare result |
| pe_state_i | input | N*(D+1) | Distance state bits, PE(i,j) at bit i*(D+1)+j |
| busy_o | output | 1 | Reporting in progress |
| hit_valid_o | output | 1 | `hit_addr_o` and `hit_dist_o` carry a hit |
| hit_addr_o | output | clog2(N) | Start address of the matched keyword |
| hit_dist_o | output | max(1,clog2(D+1)) | Lowest error count of that keyword |
| done_o | output | 1 | One-cycle pulse closing a run |

## Verification
The bench builds the block with N=16 cells and D=2, with distance reporting enabled. Sixteen cells leave room for four keywords. They also allow a delimiter in cell 0 and adjacent delimiters, so the no-previous-delimiter rule and the empty-keyword corner both show up at the address port. D=2 gives three distance bits per cell, which is enough to show that the lowest set bit wins over higher ones. A full four-hit drain and a zero-hit run bound the done timing on both sides.

// File: rtl/wmd_pkg.sv
package wmd_pkg;

   // width of an error-count field able to hold 0..d
   function automatic int dist_bits(input int d);
      return (d < 1) ? 1 : $clog2(d + 1);
   endfunction

   // width of a cell address for n cells
   function automatic int addr_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wmd_hit_detect.sv
module wmd_hit_detect
   import wmd_pkg::*;
#(
   parameter int N           = 16,
   parameter int D           = 2,
   parameter bit REPORT_DIST = 1'b1,
   localparam int DW         = dist_bits(D),
   localparam int SW         = D + 1
) (
   input  logic              end_i,
   input  logic [N-1:0]      delim_i,
   input  logic [N-1:0]      m_i,
   input  logic [N*SW-1:0]   pe_i,
   output logic [N-1:0]      wm_o,
   output logic [N*DW-1:0]   dist_o
);

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic any_state;
      assign any_state = |pe_i[i*SW +: SW];
      assign wm_o[i]   = end_i & delim_i[i] & m_i[i] & any_state;

      if (REPORT_DIST) begin : g_dist
         logic [DW-1:0] md;
         always_comb begin
            md = '0;
            for (int j = D; j >= 0; j--) begin
               if (pe_i[i*SW + j]) md = DW'(j);
            end
         end
         assign dist_o[i*DW +: DW] = md;
      end else begin : g_nodist
         assign dist_o[i*DW +: DW] = '0;
      end
   end

endmodule

// File: rtl/wmd_start_map.sv
module wmd_start_map
   import wmd_pkg::*;
#(
   parameter int N  = 16,
   parameter int DW = 2,
   localparam int AW = addr_bits(N)
) (
   input  logic [N-1:0]    delim_i,
   input  logic [N-1:0]    wm_i,
   input  logic [N*DW-1:0] dist_i,
   output logic [N-1:0]    mp_o,
   output logic [N*DW-1:0] dist_o
);

   logic [AW-1:0] base;

   always_comb begin
      mp_o   = '0;
      dist_o = '0;
      base   = '0;
      for (int i = 0; i < N; i++) begin
         if (delim_i[i]) begin
            if (wm_i[i]) begin
               mp_o[base]                     = 1'b1;
               dist_o[int'(base)*DW +: DW]    = dist_i[i*DW +: DW];
            end
            base = AW'(i + 1);
         end
      end
   end

endmodule

// File: rtl/wmd_prio_tree.sv
module wmd_prio_tree
   import wmd_pkg::*;
#(
   parameter int N   = 16,
   localparam int AW = addr_bits(N),
   localparam int P  = 1 << AW
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [AW-1:0] idx_o
);

   for (genvar l = 0; l <= AW; l++) begin : lvl
      localparam int W = P >> l;
      logic [W-1:0]  v;
      logic [AW-1:0] ix [W];
      if (l == 0) begin : g_leaf
         for (genvar k = 0; k < W; k++) begin : g_k
            if (k < N) begin : g_real
               assign v[k] = req_i[k];
            end else begin : g_pad
               assign v[k] = 1'b0;
            end
            assign ix[k] = AW'(k);
         end
      end else begin : g_node
         for (genvar k = 0; k < W; k++) begin : g_k
            assign v[k]  = lvl[l-1].v[2*k] | lvl[l-1].v[2*k+1];
            assign ix[k] = lvl[l-1].v[2*k] ? lvl[l-1].ix[2*k] : lvl[l-1].ix[2*k+1];
         end
      end
   end

   assign any_o = lvl[AW].v[0];
   assign idx_o = lvl[AW].ix[0];

endmodule

// File: rtl/wmatch_addr_encoder.sv
module wmatch_addr_encoder
   import wmd_pkg::*;
#(
   parameter int N           = 16,
   parameter int D           = 2,
   parameter bit REPORT_DIST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    word_end_i,
   input  logic [N-1:0]            delim_i,
   input  logic [N-1:0]            cmp_hit_i,
   input  logic [N*(D+1)-1:0]      pe_state_i,
   output logic                    busy_o,
   output logic                    hit_valid_o,
   output logic [addr_bits(N)-1:0] hit_addr_o,
   output logic [dist_bits(D)-1:0] hit_dist_o,
   output logic                    done_o
);

   localparam int AW = addr_bits(N);
   localparam int DW = dist_bits(D);

   if (N < 2) begin : g_bad_n
      $error("wmatch_addr_encoder: N must be at least 2");
   end
   if (D < 0) begin : g_bad_d
      $error("wmatch_addr_encoder: D must not be negative");
   end

   logic [N-1:0]    wm;
   logic [N*DW-1:0] cell_dist;
   logic [N-1:0]    mp;
   logic [N*DW-1:0] start_dist;

   logic            busy_q;
   logic [N-1:0]    pend_q;
   logic [N*DW-1:0] dstore_q;

   logic            any_pend;
   logic [AW-1:0]   sel_idx;
   logic            accept;

   wmd_hit_detect #(.N(N), .D(D), .REPORT_DIST(REPORT_DIST)) u_detect (
      .end_i   (word_end_i),
      .delim_i (delim_i),
      .m_i     (cmp_hit_i),
      .pe_i    (pe_state_i),
      .wm_o    (wm),
      .dist_o  (cell_dist)
   );

   wmd_start_map #(.N(N), .DW(DW)) u_map (
      .delim_i (delim_i),
      .wm_i    (wm),
      .dist_i  (cell_dist),
      .mp_o    (mp),
      .dist_o  (start_dist)
   );

   wmd_prio_tree #(.N(N)) u_tree (
      .req_i (pend_q),
      .any_o (any_pend),
      .idx_o (sel_idx)
   );

   assign accept = word_end_i & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pend_q   <= '0;
         dstore_q <= '0;
      end else if (accept) begin
         busy_q   <= 1'b1;
         pend_q   <= mp;
         dstore_q <= start_dist;
      end else if (busy_q) begin
         if (any_pend) begin
            pend_q[sel_idx] <= 1'b0;
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o      = busy_q;
   assign hit_valid_o = busy_q & any_pend;
   assign done_o      = busy_q & ~any_pend;
   assign hit_addr_o  = sel_idx;
   assign hit_dist_o  = dstore_q[int'(sel_idx)*DW +: DW];

endmodule

// File: rtl/wmatch_addr_encoder_chk.sv
module wmatch_addr_encoder_chk
   import wmd_pkg::*;
#(
   parameter int N = 16,
   parameter int D = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    word_end_i,
   input logic                    busy_o,
   input logic                    hit_valid_o,
   input logic [addr_bits(N)-1:0] hit_addr_o,
   input logic [dist_bits(D)-1:0] hit_dist_o,
   input logic                    done_o
);

   a_r4_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid_o |-> busy_o);

   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid_o |=> (!hit_valid_o || (hit_addr_o > $past(hit_addr_o))));

   a_r5_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && !hit_valid_o));

   a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!busy_o && !done_o));

   a_r6_run_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   a_r8_start_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(word_end_i));

   a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid_o |-> (int'(hit_addr_o) < N));

   a_r7_dist_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid_o |-> (int'(hit_dist_o) <= D));

endmodule

bind wmatch_addr_encoder wmatch_addr_encoder_chk #(.N(N), .D(D)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .word_end_i  (word_end_i),
   .busy_o      (busy_o),
   .hit_valid_o (hit_valid_o),
   .hit_addr_o  (hit_addr_o),
   .hit_dist_o  (hit_dist_o),
   .done_o      (done_o)
);

// File: tb/wmatch_addr_encoder_bench.sv
`timescale 1ns/1ps
module wmatch_addr_encoder_bench;

   localparam int N   = 16;
   localparam int D   = 2;
   localparam int SW  = D + 1;
   localparam int PEW = N * SW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           word_end_i = 1'b0;
   logic [N-1:0]   delim_i = '0;
   logic [N-1:0]   cmp_hit_i = '0;
   logic [PEW-1:0] pe_state_i = '0;
   logic           busy_o, hit_valid_o, done_o;
   logic [3:0]     hit_addr_o;
   logic [1:0]     hit_dist_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int exp_addr [$];
   int exp_dist [$];

   always #10 clk = ~clk;

   wmatch_addr_encoder #(.N(N), .D(D), .REPORT_DIST(1'b1)) u_wmatch_addr_encoder (
      .clk(clk), .rst_n(rst_n), .word_end_i(word_end_i), .delim_i(delim_i),
      .cmp_hit_i(cmp_hit_i), .pe_state_i(pe_state_i), .busy_o(busy_o),
      .hit_valid_o(hit_valid_o), .hit_addr_o(hit_addr_o), .hit_dist_o(hit_dist_o),
      .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
         finish_run();
      end
   end

   // monitor: compare each reported hit with the scoreboard
   always @(negedge clk) begin
      if (rst_n && hit_valid_o) begin
         if (exp_addr.size() == 0) begin
            check(1'b0, "R4 unexpected hit", int'(hit_addr_o), -1);
         end else begin
            int ea, ed;
            ea = exp_addr.pop_front();
            ed = exp_dist.pop_front();
            check(int'(hit_addr_o) == ea, "R3 hit address", int'(hit_addr_o), ea);
            check(int'(hit_dist_o) == ed, "R7 hit distance", int'(hit_dist_o), ed);
         end
      end
   end

   function automatic logic [PEW-1:0] pe_bit(input int i, input int j);
      logic [PEW-1:0] v = '0;
      v[i*SW + j] = 1'b1;
      return v;
   endfunction

   // driver: predict hits from the requirements, then run one word
   task automatic run_word(input logic [N-1:0] dl, input logic [N-1:0] m,
                           input logic [PEW-1:0] pe, input bit poke, input string tag);
      int q = 0;
      int cyc = 0;
      for (int i = 0; i < N; i++) begin
         if (dl[i] && m[i] && (|pe[i*SW +: SW])) begin
            int s = 0;
            int d = 0;
            for (int k = i - 1; k >= 0; k--) begin
               if (dl[k]) begin s = k + 1; break; end
            end
            for (int j = D; j >= 0; j--) if (pe[i*SW + j]) d = j;
            exp_addr.push_back(s);
            exp_dist.push_back(d);
            q++;
         end
      end
      @(negedge clk);
      delim_i = dl; cmp_hit_i = m; pe_state_i = pe; word_end_i = 1'b1;
      @(negedge clk);
      word_end_i = 1'b0;
      forever begin
         cyc++;
         check(busy_o == 1'b1, {"R8 busy during run ", tag}, int'(busy_o), 1);
         if (done_o) break;
         if (cyc > N + 4) begin
            check(1'b0, {"R5 done missing ", tag}, cyc, q + 1);
            break;
         end
         if (poke && cyc == 1) begin
            word_end_i = 1'b1; delim_i = '1; cmp_hit_i = '1; pe_state_i = '1;
         end else begin
            word_end_i = 1'b0;
         end
         @(negedge clk);
      end
      check(cyc == q + 1, {"R5 done timing ", tag}, cyc, q + 1);
      check(exp_addr.size() == 0, {"R4 all hits reported ", tag}, exp_addr.size(), 0);
      if (poke) begin
         word_end_i = 1'b1; delim_i = '1; cmp_hit_i = '1; pe_state_i = '1;
      end
      @(negedge clk);
      word_end_i = 1'b0;
      check(busy_o == 1'b0, {"R8 busy falls after done ", tag}, int'(busy_o), 0);
      check(done_o == 1'b0, {"R5 done single cycle ", tag}, int'(done_o), 0);
      @(negedge clk);
      check(busy_o == 1'b0 && hit_valid_o == 1'b0, {"R6 no new run ", tag},
            int'(busy_o | hit_valid_o), 0);
      exp_addr.delete();
      exp_dist.delete();
   endtask

   initial begin
      logic [N-1:0]   dl, m;
      logic [PEW-1:0] pe;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && hit_valid_o == 1'b0 && done_o == 1'b0,
            "R1 reset state", int'({busy_o, hit_valid_o, done_o}), 0);
      rst_n = 1'b1;
      // R2: hit data present but no end of word
      delim_i = '1; cmp_hit_i = '1; pe_state_i = '1;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && hit_valid_o == 1'b0, "R2 no run without end",
            int'(busy_o | hit_valid_o), 0);
      delim_i = '0; cmp_hit_i = '0; pe_state_i = '0;

      // keywords at cells 0..3, 5..8, 10..11, 13..14; delimiters 4, 9, 12, 15
      dl = '0; dl[4] = 1; dl[9] = 1; dl[12] = 1; dl[15] = 1;

      // two hits, lowest distance chosen (R7)
      m = '0; m[4] = 1; m[12] = 1;
      pe = pe_bit(4, 1) | pe_bit(4, 2) | pe_bit(12, 0) | pe_bit(12, 2);
      run_word(dl, m, pe, 1'b0, "two hits");

      // R2: non-delimiter cell, missing state, missing compare -> no hits
      m = '0; m[7] = 1; m[9] = 1;
      pe = pe_bit(7, 0) | pe_bit(15, 1);
      run_word(dl, m, pe, 1'b0, "zero hits");

      // all four keywords at distance 2
      m = dl;
      pe = pe_bit(4, 2) | pe_bit(9, 2) | pe_bit(12, 2) | pe_bit(15, 2);
      run_word(dl, m, pe, 1'b0, "four hits");

      // R3: delimiter at cell 0 and adjacent delimiters
      dl = '0; dl[0] = 1; dl[1] = 1; dl[15] = 1;
      m = dl;
      pe = pe_bit(0, 0) | pe_bit(1, 1) | pe_bit(15, 0);
      run_word(dl, m, pe, 1'b0, "adjacent delimiters");

      // R3: single keyword filling the array
      dl = '0; dl[15] = 1; m = dl; pe = pe_bit(15, 1);
      run_word(dl, m, pe, 1'b0, "single keyword");

      // R6: end pulses while busy and in the done cycle are ignored
      dl = '0; dl[4] = 1; dl[9] = 1; dl[12] = 1; dl[15] = 1;
      m = '0; m[9] = 1; m[15] = 1;
      pe = pe_bit(9, 0) | pe_bit(15, 2);
      run_word(dl, m, pe, 1'b1, "ignored end");

      finish_run();
   end

endmodule